// File: doc/BRIEF.md
# Programmable Skew Clock Output Bank

This block is a synchronous model of a clock distributor with four output banks of two outputs each. It runs on a fast tick clock, and one tick is the time unit of the skew steps. An internal reference is generated with a period of 44, 26 or 16 ticks, chosen by a three-level frequency select. A test input can replace this reference with an external one. Every output bank takes its waveform from a shared delay history of that reference. Banks A and B can be moved earlier or later by up to four ticks. Bank C can be moved by up to six ticks in steps of two, or it can output the reference divided by two or by four. Bank Z has no skew.

Each control input has three levels and is carried on two wires. The skew code of a bank is a pair of such symbols. A stop input parks banks A, B and Z low and leaves bank C running, so that bank C can serve as a feedback clock. In the middle test level, the stop input instead parks only the banks whose code is low-low. Configuration is captured on each rising edge of the reference, which is the period boundary.

Each bank has a stop gate, which is a state machine with three states. RUN passes the waveform through. DRAIN is entered from RUN when a stop is requested while the waveform is high; it keeps passing the waveform until the waveform goes low. HALT holds the output low. The transitions are:
- RUN→DRAIN: stop requested, waveform high.
- RUN→HALT: stop requested, waveform low.
- DRAIN→HALT: waveform has fallen.
- DRAIN→RUN: request withdrawn.
- HALT→RUN: request withdrawn and waveform low.

Top module: `skew_clock_bank`

## Requirements
- R1: The internal reference period is 44, 26 or 16 ticks when `freq_sel` is LOW, MID or HIGH. Every output with no skew and no division is high for exactly half of that period.
- R2: Each three-level input uses the encoding 2'b00 = LOW, 2'b01 = MID, 2'b10 = HIGH, and 2'b11 is read as MID. A skew code is {first symbol in [3:2], second symbol in [1:0]}.
- R3: Banks A and B decode the codes LL, LM, LH, ML, MM, MH, HL, HM, HH to offsets of -4 through +4 ticks. A bank's rising edge follows the rising edge of bank Z by (offset mod period) ticks.
- R4: Bank C decodes LM, LH, ML, MM, MH, HL, HM to offsets of -6, -4, -2, 0, +2, +4, +6 ticks, with the same timing rule as R3.
- R5: Bank C with code LL outputs the reference divided by 2. With code HH it outputs the reference divided by 4. With `rise_align` high, its rising edges coincide with rising edges of bank Z.
- R6: With `rise_align` low, the divided outputs of bank C change on falling edges of bank Z.
- R7: With `out_stop` high and `test_mode` not MID, banks A, B and Z stop LOW and bank C keeps running. On stop and on restart, every high pulse keeps its full length.
- R8: With `test_mode` MID and `out_stop` high, only the banks whose code is LL are parked LOW. Banks with other codes, and bank Z, keep running.
- R9: With `test_mode` MID or HIGH, `ref_in` replaces the internal reference for all banks, and the skew codes still apply.
- R10: The two outputs of a bank are always identical.
- R11: A new skew code or stop setting takes effect only at the next rising edge of the reference.
- R12: While reset is held, all outputs are LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock; one tick is one skew time unit |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_sel | input | 2 | Three-level period select |
| test_mode | input | 2 | Three-level test select; MID or HIGH selects external reference |
| out_stop | input | 1 | High parks outputs low at the next boundary |
| rise_align | input | 1 | High: dividers step on rising reference edges; low: on falling edges |
| ref_in | input | 1 | External reference used in test mode |
| skew_a | input | 4 | Skew code of bank A |
| skew_b | input | 4 | Skew code of bank B |
| skew_c | input | 4 | Skew or divide code of bank C |
| q_a | output | 2 | Bank A outputs |
| q_b | output | 2 | Bank B outputs |
| q_c | output | 2 | Bank C outputs |
| q_z | output | 2 | Zero-skew bank outputs |

## Verification
The hardest situation to reach is a stop request that arrives while an output is in the middle of a high pulse. To catch a truncated pulse, the width of every completed high pulse is measured over the stop window and over the restart window. The per-bank disable case needs the middle test level, so the external reference must be running: a free-running square wave is driven on `ref_in` for that case. Skew is always measured as the tick distance from a rising edge of bank Z, so the checks do not depend on the pipeline latency.

// File: rtl/skew_pkg.sv
package skew_pkg;

    typedef enum logic [1:0] {
        LV_LOW  = 2'b00,
        LV_MID  = 2'b01,
        LV_HIGH = 2'b10
    } lvl_t;

    typedef enum logic [1:0] {
        GT_RUN   = 2'b00,
        GT_DRAIN = 2'b01,
        GT_HALT  = 2'b10
    } gate_t;

    localparam logic [3:0] IDX_LL  = 4'd0;
    localparam logic [3:0] IDX_HH  = 4'd8;
    localparam logic [3:0] CODE_MM = 4'b0101;

    // Three-level decode; the unused encoding falls back to MID
    function automatic lvl_t to_lvl(input logic [1:0] raw);
        lvl_t v;
        case (raw)
            2'b00:   v = LV_LOW;
            2'b10:   v = LV_HIGH;
            default: v = LV_MID;
        endcase
        return v;
    endfunction

    // Position of a symbol pair in the order LL, LM, LH, ML, ... HH
    function automatic logic [3:0] code_idx(input logic [3:0] c);
        return 4'(3 * int'(to_lvl(c[3:2])) + int'(to_lvl(c[1:0])));
    endfunction

    // Signed offset in ticks; wide banks step by two
    function automatic int skew_units(input logic [3:0] c, input logic wide);
        int i;
        i = int'(code_idx(c)) - 4;
        return wide ? 2 * i : i;
    endfunction

endpackage

// File: rtl/skew_timebase.sv
module skew_timebase
    import skew_pkg::*;
#(
    parameter int PER_LO  = 44,
    parameter int PER_MID = 26,
    parameter int PER_HI  = 16,
    parameter int PW      = $clog2(PER_LO + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    freq_sel,
    output logic [PW-1:0] per,
    output logic          gen
);

    logic [PW-1:0] phase;
    logic [PW-1:0] per_nx;

    always_comb begin
        case (to_lvl(freq_sel))
            LV_LOW:  per_nx = PW'(PER_LO);
            LV_HIGH: per_nx = PW'(PER_HI);
            default: per_nx = PW'(PER_MID);
        endcase
    end

    // Period changes only at a wrap so no cycle is cut short
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            per   <= PW'(PER_MID);
        end else if (phase == per - PW'(1)) begin
            phase <= '0;
            per   <= per_nx;
        end else begin
            phase <= phase + PW'(1);
        end
    end

    assign gen = (phase < (per >> 1));

    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        phase < per); // R1
    AST_PER_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (per == PW'(PER_LO)) || (per == PW'(PER_MID)) || (per == PW'(PER_HI))); // R1
    AST_PER_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(per) |-> ($past(phase) == $past(per) - PW'(1))); // R1

endmodule

// File: rtl/skew_gate.sv
module skew_gate
    import skew_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic wave,
    output logic out
);

    gate_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GT_RUN:   if (stop_req) state_d = wave ? GT_DRAIN : GT_HALT;
            GT_DRAIN: if (!stop_req) state_d = GT_RUN;
                      else if (!wave) state_d = GT_HALT;
            GT_HALT:  if (!stop_req && !wave) state_d = GT_RUN;
            default:  state_d = GT_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GT_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        out = (state_q == GT_HALT) ? 1'b0 : wave;
    end

    AST_HALT_ENTRY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == GT_HALT) |-> !$past(wave)); // R7
    AST_RESUME_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state_q == GT_HALT) |-> !$past(wave)); // R7
    AST_HALT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == GT_HALT) |-> $past(stop_req)); // R7

endmodule

// File: rtl/skew_clock_bank.sv
module skew_clock_bank
    import skew_pkg::*;
#(
    parameter int PER_LO  = 44,
    parameter int PER_MID = 26,
    parameter int PER_HI  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] freq_sel,
    input  logic [1:0] test_mode,
    input  logic       out_stop,
    input  logic       rise_align,
    input  logic       ref_in,
    input  logic [3:0] skew_a,
    input  logic [3:0] skew_b,
    input  logic [3:0] skew_c,
    output logic [1:0] q_a,
    output logic [1:0] q_b,
    output logic [1:0] q_c,
    output logic [1:0] q_z
);

    localparam int NB = 3;                 // skewed banks; index NB is bank Z
    localparam int HD = PER_LO + 1;        // history depth: lag up to period-1, plus one
    localparam int PW = $clog2(PER_LO + 2);

    logic [PW-1:0]        per;
    logic                 gen;
    logic                 bypass, tmid, refsig;
    logic [HD-1:0]        hist;
    logic                 bnd, fall_ev, div_ev;
    logic [1:0]           divcnt;
    logic                 div2, div4;
    logic [NB-1:0][3:0]   skew_in;
    logic [NB-1:0][3:0]   code_q;
    logic [NB-1:0][PW-1:0] lag_q, lag_d;
    logic [NB:0]          stop_q, stop_d;
    logic [NB:0]          wave, qo;

    skew_timebase #(
        .PER_LO (PER_LO),
        .PER_MID(PER_MID),
        .PER_HI (PER_HI),
        .PW     (PW)
    ) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .freq_sel(freq_sel),
        .per     (per),
        .gen     (gen)
    );

    assign bypass  = (to_lvl(test_mode) != LV_LOW);
    assign tmid    = (to_lvl(test_mode) == LV_MID);
    assign refsig  = bypass ? ref_in : gen;
    assign skew_in = {skew_c, skew_b, skew_a};

    // Rising reference edge is the period boundary
    assign bnd     = hist[0] & ~hist[1];
    assign fall_ev = ~hist[0] & hist[1];
    assign div_ev  = rise_align ? bnd : fall_ev;
    assign div2    = ~divcnt[0];
    assign div4    = ~divcnt[1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist   <= '0;
            divcnt <= 2'b11;
            code_q <= {NB{CODE_MM}};
            lag_q  <= '0;
            stop_q <= '0;
        end else begin
            hist <= {hist[HD-2:0], refsig};
            if (div_ev) divcnt <= divcnt + 2'd1;
            if (bnd) begin
                code_q <= skew_in;
                lag_q  <= lag_d;
                stop_q <= stop_d;
            end
        end
    end

    for (genvar b = 0; b < NB; b++) begin : g_bank
        localparam logic WIDE = (b == NB - 1);
        int off;

        always_comb begin
            off = skew_units(skew_in[b], WIDE);
            lag_d[b] = (off < 0) ? PW'(int'(per) + off) : PW'(off);
            if (tmid && out_stop) stop_d[b] = (code_idx(skew_in[b]) == IDX_LL);
            else                  stop_d[b] = out_stop && !WIDE;
        end

        if (WIDE) begin : g_div
            always_comb begin
                if (code_idx(code_q[b]) == IDX_LL)      wave[b] = div2;
                else if (code_idx(code_q[b]) == IDX_HH) wave[b] = div4;
                else                                    wave[b] = hist[lag_q[b] + PW'(1)];
            end
        end else begin : g_skew
            assign wave[b] = hist[lag_q[b] + PW'(1)];
        end

        skew_gate u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .stop_req(stop_q[b]),
            .wave    (wave[b]),
            .out     (qo[b])
        );
    end

    assign stop_d[NB] = out_stop && !tmid;
    assign wave[NB]   = hist[1];

    skew_gate u_gate_z (
        .clk     (clk),
        .rst_n   (rst_n),
        .stop_req(stop_q[NB]),
        .wave    (wave[NB]),
        .out     (qo[NB])
    );

    assign q_a = {2{qo[0]}};
    assign q_b = {2{qo[1]}};
    assign q_c = {2{qo[2]}};
    assign q_z = {2{qo[NB]}};

    AST_CFG_AT_BND: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(lag_q) || !$stable(code_q) || !$stable(stop_q)) |-> $past(bnd)); // R11
    AST_DIV_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(divcnt) |-> $past(div_ev)); // R5
    AST_C_STOP_ONLY_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_q[NB-1]) |-> $past(tmid && out_stop)); // R8
    AST_Z_STOP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_q[NB]) |-> $past(out_stop && !tmid)); // R7
    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> (!rst_n -> (qo == '0))); // R12

endmodule

// File: tb/skew_clock_bank_tb.sv
`timescale 1ns/1ps
module skew_clock_bank_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] freq_sel = 2'b01;
    logic [1:0] test_mode = 2'b00;
    logic       out_stop = 1'b0;
    logic       rise_align = 1'b1;
    logic       ref_in = 1'b0;
    logic [3:0] skew_a = 4'b0101;
    logic [3:0] skew_b = 4'b0101;
    logic [3:0] skew_c = 4'b0101;
    logic [1:0] q_a, q_b, q_c, q_z;

    int total = 0;
    int bad = 0;
    int ref_half = 0;
    int ref_cnt = 0;
    bit done = 0;

    always #2 clk = ~clk;

    skew_clock_bank u_dut (
        .clk(clk), .rst_n(rst_n), .freq_sel(freq_sel), .test_mode(test_mode),
        .out_stop(out_stop), .rise_align(rise_align), .ref_in(ref_in),
        .skew_a(skew_a), .skew_b(skew_b), .skew_c(skew_c),
        .q_a(q_a), .q_b(q_b), .q_c(q_c), .q_z(q_z)
    );

    // External square-wave reference
    always @(negedge clk) begin
        if (ref_half == 0) begin
            ref_in <= 1'b0; ref_cnt <= 0;
        end else if (ref_cnt >= ref_half - 1) begin
            ref_in <= ~ref_in; ref_cnt <= 0;
        end else begin
            ref_cnt <= ref_cnt + 1;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic obit(input int b);
        case (b)
            0: return q_a[0];
            1: return q_b[0];
            2: return q_c[0];
            default: return q_z[0];
        endcase
    endfunction

    task automatic settle();
        repeat (200) @(negedge clk);
    endtask

    task automatic wait_rise(input int b);
        logic p; int n;
        p = obit(b); n = 0;
        @(negedge clk);
        while (!(obit(b) && !p) && n < 1000) begin
            p = obit(b); @(negedge clk); n++;
        end
    endtask

    task automatic meas_wave(input int b, output int per, output int hi);
        int lo;
        wait_rise(b);
        hi = 0; lo = 0;
        while (obit(b) && hi < 1000) begin @(negedge clk); hi++; end
        while (!obit(b) && lo < 1000) begin @(negedge clk); lo++; end
        per = hi + lo;
    endtask

    // Ticks from a rising edge of rb to the next edge (rise or fall) of b
    task automatic meas_lag(input int rb, input int b, input bit tfall,
                            input int maxn, output int lag);
        logic pr, pb; int n;
        pr = obit(rb); pb = obit(b); n = 0; lag = -1;
        @(negedge clk);
        while (!(obit(rb) && !pr) && n < 1000) begin
            pr = obit(rb); pb = obit(b); @(negedge clk); n++;
        end
        for (int k = 0; k < maxn && lag < 0; k++) begin
            if (tfall ? (!obit(b) && pb) : (obit(b) && !pb)) lag = k;
            pb = obit(b);
            @(negedge clk);
        end
    endtask

    task automatic watch(input int n, input int half, output int badw, output int ra,
                         output int rb, output int rc, output int rz, output int hab);
        logic pa, pbb, pc, pz; int wa, wz; bit ina, inz;
        pa = q_a[0]; pbb = q_b[0]; pc = q_c[0]; pz = q_z[0];
        wa = 0; wz = 0; ina = 0; inz = 0;
        badw = 0; ra = 0; rb = 0; rc = 0; rz = 0; hab = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (q_a[0] || q_b[0] || q_z[0]) hab++;
            if (q_a[0] && !pa) begin ra++; ina = 1; wa = 0; end
            if (ina && q_a[0]) wa++;
            if (ina && !q_a[0] && pa) begin if (wa != half) badw++; ina = 0; end
            if (q_z[0] && !pz) begin rz++; inz = 1; wz = 0; end
            if (inz && q_z[0]) wz++;
            if (inz && !q_z[0] && pz) begin if (wz != half) badw++; inz = 0; end
            if (q_b[0] && !pbb) rb++;
            if (q_c[0] && !pc) rc++;
            pa = q_a[0]; pbb = q_b[0]; pc = q_c[0]; pz = q_z[0];
        end
    endtask

    task automatic t_reset();
        int highs = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (q_a != 0 || q_b != 0 || q_c != 0 || q_z != 0) highs++;
        end
        chk("R12 outputs low in reset", highs, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_period();
        int p, h;
        freq_sel = 2'b00; settle(); meas_wave(3, p, h);
        chk("R1 period LOW", p, 44); chk("R1 high LOW", h, 22);
        freq_sel = 2'b01; settle(); meas_wave(3, p, h);
        chk("R1 period MID", p, 26); chk("R1 high MID", h, 13);
        freq_sel = 2'b10; settle(); meas_wave(3, p, h);
        chk("R1 period HIGH", p, 16); chk("R1 high HIGH", h, 8);
        freq_sel = 2'b11; settle(); meas_wave(3, p, h);
        chk("R2 illegal select reads MID", p, 26);
    endtask

    task automatic t_skew_ab();
        int l;
        freq_sel = 2'b01;
        skew_a = 4'b0000; skew_b = 4'b1010; settle();
        meas_lag(3, 0, 0, 40, l); chk("R3 bank A LL lag", l, 22);
        meas_lag(3, 1, 0, 40, l); chk("R3 bank B HH lag", l, 4);
        skew_a = 4'b0010; skew_b = 4'b0100; settle();
        meas_lag(3, 0, 0, 40, l); chk("R3 bank A LH lag", l, 24);
        meas_lag(3, 1, 0, 40, l); chk("R3 bank B ML lag", l, 25);
        skew_a = 4'b1110; skew_b = 4'b1001; settle();
        meas_lag(3, 0, 0, 40, l); chk("R2 code 11,10 reads MH", l, 1);
        meas_lag(3, 1, 0, 40, l); chk("R3 bank B HM lag", l, 3);
        skew_a = 4'b0101; skew_b = 4'b0101;
    endtask

    task automatic t_skew_c();
        int l;
        freq_sel = 2'b01;
        skew_c = 4'b0001; settle();
        meas_lag(3, 2, 0, 40, l); chk("R4 bank C LM lag", l, 20);
        skew_c = 4'b1001; settle();
        meas_lag(3, 2, 0, 40, l); chk("R4 bank C HM lag", l, 6);
        skew_c = 4'b0110; settle();
        meas_lag(3, 2, 0, 40, l); chk("R4 bank C MH lag", l, 2);
        skew_c = 4'b0101;
    endtask

    task automatic t_divide();
        int p, h, l;
        freq_sel = 2'b10; rise_align = 1'b1;
        skew_c = 4'b0000; settle(); meas_wave(2, p, h);
        chk("R5 div2 period", p, 32); chk("R5 div2 high", h, 16);
        meas_lag(2, 3, 0, 8, l); chk("R5 div2 rise on Z rise", l, 0);
        skew_c = 4'b1010; settle(); meas_wave(2, p, h);
        chk("R5 div4 period", p, 64); chk("R5 div4 high", h, 32);
        meas_lag(2, 3, 0, 8, l); chk("R5 div4 rise on Z rise", l, 0);
        rise_align = 1'b0; settle(); meas_lag(2, 3, 1, 8, l);
        chk("R6 div4 rise on Z fall", l, 0);
        skew_c = 4'b0000; settle(); meas_wave(2, p, h);
        chk("R6 div2 period falling mode", p, 32);
        meas_lag(2, 3, 1, 8, l); chk("R6 div2 rise on Z fall", l, 0);
        rise_align = 1'b1; skew_c = 4'b0101; settle();
    endtask

    task automatic t_stop();
        int bw, ra, rb, rc, rz, hab;
        freq_sel = 2'b10; skew_a = 4'b0110; settle();
        out_stop = 1'b1;
        watch(48, 8, bw, ra, rb, rc, rz, hab);
        chk("R7 no truncated pulse entering stop", bw, 0);
        watch(32, 8, bw, ra, rb, rc, rz, hab);
        chk("R7 banks A B Z parked low", hab, 0);
        chk("R7 bank C keeps running", (rc >= 1) ? 1 : 0, 1);
        out_stop = 1'b0;
        watch(64, 8, bw, ra, rb, rc, rz, hab);
        chk("R7 no truncated pulse on restart", bw, 0);
        chk("R7 bank Z resumes", (rz >= 2) ? 1 : 0, 1);
        skew_a = 4'b0101;
    endtask

    task automatic t_cfg_boundary();
        int mis = 0; int l;
        freq_sel = 2'b01; skew_a = 4'b0101; settle();
        wait_rise(3);
        skew_a = 4'b1010;
        for (int i = 0; i < 22; i++) begin
            if (q_a[0] != q_z[0]) mis++;
            @(negedge clk);
        end
        chk("R11 old code holds until boundary", mis, 0);
        settle(); meas_lag(3, 0, 0, 40, l);
        chk("R11 new code after boundary", l, 4);
        skew_a = 4'b0101;
    endtask

    task automatic t_pairs();
        int mis = 0;
        skew_a = 4'b0011; skew_b = 4'b1000; skew_c = 4'b0000; settle();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (q_a[0] != q_a[1] || q_b[0] != q_b[1] || q_c[0] != q_c[1] || q_z[0] != q_z[1])
                mis++;
        end
        chk("R10 pair outputs identical", mis, 0);
        skew_a = 4'b0101; skew_b = 4'b0101; skew_c = 4'b0101;
    endtask

    task automatic t_bypass();
        int p, h, l;
        freq_sel = 2'b10; ref_half = 10; test_mode = 2'b10; settle();
        meas_wave(3, p, h);
        chk("R9 bypass period follows ref_in", p, 20); chk("R9 bypass high", h, 10);
        skew_a = 4'b0110; settle(); meas_lag(3, 0, 0, 30, l);
        chk("R9 skew applies in bypass", l, 1);
        skew_a = 4'b0101;
    endtask

    task automatic t_bank_disable();
        int bw, ra, rb, rc, rz, hab;
        freq_sel = 2'b10; ref_half = 8; test_mode = 2'b01;
        skew_a = 4'b0000; skew_b = 4'b0101; skew_c = 4'b0101; settle();
        out_stop = 1'b1; settle();
        watch(64, 8, bw, ra, rb, rc, rz, hab);
        chk("R8 LL bank A parked", ra, 0);
        chk("R8 bank B keeps running", (rb >= 2) ? 1 : 0, 1);
        chk("R8 bank Z keeps running", (rz >= 2) ? 1 : 0, 1);
        chk("R8 bank C keeps running", (rc >= 2) ? 1 : 0, 1);
        out_stop = 1'b0; test_mode = 2'b00; ref_half = 0; skew_a = 4'b0101; settle();
    endtask

    initial begin
        t_reset();
        settle();
        t_period();
        t_skew_ab();
        t_skew_c();
        t_divide();
        t_stop();
        t_cfg_boundary();
        t_pairs();
        t_bank_disable();
        t_bypass();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule